// File: doc/BRIEF.md
# Single-Address DMA Channel

This block is one DMA channel that moves data between an external peripheral and external memory in single-address form. The memory sees an address, a chip select and either a write or a read strobe. The peripheral sees only an active-low acknowledge. During the acknowledged access the peripheral drives the shared data bus (peripheral to memory) or takes data from it (memory to peripheral). No data passes through the channel.

Software loads a start address, a unit count, a direction, a unit size and a bus mode, then raises the enable. Peripheral requests are latched. The channel asks an arbiter for the bus, runs one transfer unit per request, and counts units down to zero. In cycle-steal mode it gives the bus back after every unit. In burst mode it keeps the bus from the first request until the count runs out. When the count reaches zero the channel raises a done flag. The flag stays high until the enable is dropped.

Top module: `sa_dma_channel`

## Requirements
- R1: With `dir`=0 (peripheral to memory) every access drives `mem_cs_n`=0, `mem_we_n`=0 and `mem_rd_n`=1. With `dir`=1 (memory to peripheral) every access drives `mem_cs_n`=0, `mem_rd_n`=0 and `mem_we_n`=1.
- R2: `ack_n` is low in exactly the cycles in which a memory access is driven, and in no other cycle.
- R3: Once raised, `bus_req` stays high until `bus_gnt` arrives. No strobe and no acknowledge is driven in a cycle where `bus_gnt` is low.
- R4: In cycle-steal mode (`burst`=0) the channel moves one unit per grant and drops `bus_req` after each unit. A count of N gives N releases of the bus.
- R5: In burst mode (`burst`=1) a single request starts the run. `bus_req` then stays high, and the N units run back to back with one bus release at the end.
- R6: `unit_sel` encodes the unit: 0 is a byte, 1 is 16 bits, 2 is 32 bits and 3 is 16 bytes. Within a run the address rises by 1, 2, 4 or 16 per unit. A 16-byte unit takes four consecutive accesses at +0, +4, +8 and +12, with `ack_n` held low across all four.
- R7: The count drops by one per completed unit. The run stops after exactly the loaded number of units, and `done` then rises. `done` stays high, and further requests cause no access, until `enable` falls. A loaded count of zero sets `done` with no access.
- R8: A request that arrives while a unit is being served is remembered and served after that unit. A unit never starts without a request (cycle-steal mode).
- R9: After reset `bus_req`=0, `mem_cs_n`=`mem_we_n`=`mem_rd_n`=`ack_n`=1 and `done`=0.
- R10: While `enable` is low the channel loads `start_addr` and `start_count`, clears `done`, and ignores requests: `bus_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Channel enable; low loads the configuration and clears done |
| start_addr | input | ADDR_W | First memory byte address |
| start_count | input | CNT_W | Number of units to move |
| dir | input | 1 | 0 peripheral to memory (write), 1 memory to peripheral (read) |
| burst | input | 1 | 0 cycle-steal, 1 burst |
| unit_sel | input | 2 | Unit size code (see R6) |
| xfer_req | input | 1 | Transfer request from the peripheral |
| bus_req | output | 1 | Bus mastership request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| mem_addr | output | ADDR_W | Memory byte address of the current access |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| ack_n | output | 1 | Peripheral acknowledge, active low |
| done | output | 1 | Count exhausted, held until enable falls |

## Verification
A request sampled at one clock edge is latched there. `bus_req` is visible after the next edge. The first access appears one cycle after the edge that first sees `bus_gnt` high, and further beats follow one per cycle. The address and count advance, and `done` rises, at the edge that ends the last beat of a unit. The bench drives inputs just after a rising edge and samples every output on the falling edge. Its monitor compares each access against a bench-side expected address that it advances on its own. It counts accesses, acknowledges, acknowledge runs and bus releases over the whole run, then compares those totals with the table entry once `done` has been seen and a few settling cycles have passed.

// File: rtl/sa_dma_pkg.sv
// Shared types for the single-address DMA channel.
// Assumes: the 2-bit unit code is the software-visible encoding (R6).
package sa_dma_pkg;
    typedef enum logic [1:0] {
        UNIT_BYTE = 2'd0,
        UNIT_HALF = 2'd1,
        UNIT_WORD = 2'd2,
        UNIT_LINE = 2'd3
    } unit_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_XFER = 2'd2
    } state_e;
endpackage

// File: rtl/sa_dma_req_latch.sv
// Remembers a peripheral request until the sequencer consumes it.
// Assumes: a request in the same cycle as a consume stays pending.
module sa_dma_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic xfer_req,
    input  logic consume,
    output logic pend
);
    // Set on request, clear on consume, flush while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) pend <= 1'b0;
        else                   pend <= (pend && !consume) || xfer_req;
    end
endmodule

// File: rtl/sa_dma_addr_count.sv
// Holds the unit base address and remaining unit count.
// Assumes: configuration is loaded while disabled and held stable while enabled.
module sa_dma_addr_count #(
    parameter int ADDR_W     = 26,
    parameter int CNT_W      = 16,
    parameter int LINE_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  start_count,
    input  logic [1:0]        unit_sel,
    input  logic              unit_done,
    output logic [ADDR_W-1:0] base_addr,
    output logic              cnt_zero,
    output logic              cnt_last
);
    import sa_dma_pkg::*;

    logic [CNT_W-1:0]  remain;
    logic [ADDR_W-1:0] step;

    // Address increment for one unit of the selected size.
    always_comb begin
        if (unit_e'(unit_sel) == UNIT_LINE) step = ADDR_W'(LINE_BYTES);
        else                                step = ADDR_W'(1) << unit_sel;
    end

    // Load while disabled, advance once per completed unit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= '0;
            remain    <= '0;
        end else if (!enable) begin
            base_addr <= start_addr;
            remain    <= start_count;
        end else if (unit_done) begin
            base_addr <= base_addr + step;
            remain    <= remain - CNT_W'(1);
        end
    end

    assign cnt_zero = (remain == '0);
    assign cnt_last = (remain == CNT_W'(1));
endmodule

// File: rtl/sa_dma_seq.sv
// Sequencer: idle, bus request, and access beats; owns the done flag.
// Assumes: the arbiter holds the grant while bus_req stays high.
module sa_dma_seq #(
    parameter int BEATS  = 4,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              burst,
    input  logic [1:0]        unit_sel,
    input  logic              pend,
    input  logic              cnt_zero,
    input  logic              cnt_last,
    input  logic              bus_gnt,
    output sa_dma_pkg::state_e state,
    output logic [BEAT_W-1:0] beat,
    output logic              unit_done,
    output logic              consume,
    output logic              done
);
    import sa_dma_pkg::*;

    state_e            nxt;
    logic [BEAT_W-1:0] last_beat;
    logic              go;

    // Number of the final beat for the selected unit.
    assign last_beat = (unit_e'(unit_sel) == UNIT_LINE) ? BEAT_W'(BEATS - 1) : '0;
    assign go        = enable && pend && !done && !cnt_zero;
    assign consume   = (state == ST_IDLE) && go;
    assign unit_done = (state == ST_XFER) && bus_gnt && (beat == last_beat);

    // Next-state selection.
    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE: if (go) nxt = ST_REQ;
            ST_REQ:  if (!enable) nxt = ST_IDLE;
                     else if (bus_gnt) nxt = ST_XFER;
            ST_XFER: if (!enable) nxt = ST_IDLE;
                     else if (unit_done && (cnt_last || !burst)) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // State, beat counter and done flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            beat  <= '0;
            done  <= 1'b0;
        end else begin
            state <= nxt;
            if (state != ST_XFER || unit_done) beat <= '0;
            else if (bus_gnt)                  beat <= beat + BEAT_W'(1);
            if (!enable) done <= 1'b0;
            else if ((unit_done && cnt_last) || (state == ST_IDLE && cnt_zero)) done <= 1'b1;
        end
    end
endmodule

// File: rtl/sa_dma_channel.sv
// Top of the single-address DMA channel: request latch, address/count,
// sequencer and strobe decode. Data never passes through this block.
// Assumes: dir, burst and unit_sel are held stable while enable is high.
module sa_dma_channel #(
    parameter int ADDR_W    = 26,
    parameter int CNT_W     = 16,
    parameter int BUS_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  start_count,
    input  logic              dir,
    input  logic              burst,
    input  logic [1:0]        unit_sel,
    input  logic              xfer_req,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_rd_n,
    output logic              ack_n,
    output logic              done
);
    import sa_dma_pkg::*;

    localparam int LINE_BYTES = 16;
    localparam int BEATS      = LINE_BYTES / BUS_BYTES;
    localparam int BEAT_W     = (BEATS > 1) ? $clog2(BEATS) : 1;

    logic              pend, consume, unit_done, cnt_zero, cnt_last, active;
    logic [ADDR_W-1:0] base_addr;
    logic [BEAT_W-1:0] beat;
    state_e            state;

    sa_dma_req_latch u_latch (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .xfer_req(xfer_req), .consume(consume), .pend(pend)
    );

    sa_dma_addr_count #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LINE_BYTES(LINE_BYTES)) u_ac (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .start_addr(start_addr), .start_count(start_count), .unit_sel(unit_sel),
        .unit_done(unit_done), .base_addr(base_addr),
        .cnt_zero(cnt_zero), .cnt_last(cnt_last)
    );

    sa_dma_seq #(.BEATS(BEATS), .BEAT_W(BEAT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .enable(enable), .burst(burst),
        .unit_sel(unit_sel), .pend(pend), .cnt_zero(cnt_zero),
        .cnt_last(cnt_last), .bus_gnt(bus_gnt), .state(state), .beat(beat),
        .unit_done(unit_done), .consume(consume), .done(done)
    );

    // Bus request and access strobes follow the sequencer state.
    assign bus_req  = (state == ST_REQ) || (state == ST_XFER);
    assign active   = (state == ST_XFER) && bus_gnt;
    assign mem_cs_n = !active;
    assign mem_we_n = !(active && !dir);
    assign mem_rd_n = !(active && dir);
    assign ack_n    = !active;
    assign mem_addr = base_addr + ADDR_W'(beat) * ADDR_W'(BUS_BYTES);
endmodule

// File: rtl/sa_dma_channel_checks.sv
// Port-level assertions for sa_dma_channel, attached by bind.
// Assumes: synchronous active-low reset on rst_n.
module sa_dma_channel_checks (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic dir,
    input logic bus_req,
    input logic bus_gnt,
    input logic mem_cs_n,
    input logic mem_we_n,
    input logic mem_rd_n,
    input logic ack_n,
    input logic done
);
    assert_no_strobe_wo_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_gnt |-> (mem_cs_n && ack_n));

    assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt && enable) |=> bus_req);

    assert_ack_in_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |-> (!mem_cs_n && (mem_we_n != mem_rd_n)));

    assert_strobe_dir_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |-> (mem_we_n == dir && mem_rd_n == !dir));

    assert_done_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && enable) |=> done);

    assert_idle_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!bus_req && !done));
endmodule

bind sa_dma_channel sa_dma_channel_checks u_checks (
    .clk(clk), .rst_n(rst_n), .enable(enable), .dir(dir),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_cs_n(mem_cs_n),
    .mem_we_n(mem_we_n), .mem_rd_n(mem_rd_n), .ack_n(ack_n), .done(done)
);

// File: tb/test_sa_dma_channel.sv
module test_sa_dma_channel;
    localparam int ADDR_W = 26;
    localparam int CNT_W  = 16;
    localparam int NVEC   = 6;

    // Vector: [31] dir, [30] burst, [29:28] unit, [27:20] count,
    //         [19:12] expected accesses, [11:4] expected releases/ack runs, [3:0] grant delay
    localparam logic [31:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 2'd0, 8'd3, 8'd3, 8'd3, 4'd0},
        {1'b1, 1'b0, 2'd1, 8'd2, 8'd2, 8'd2, 4'd3},
        {1'b0, 1'b1, 2'd2, 8'd4, 8'd4, 8'd1, 4'd1},
        {1'b1, 1'b1, 2'd3, 8'd2, 8'd8, 8'd1, 4'd0},
        {1'b0, 1'b0, 2'd3, 8'd2, 8'd8, 8'd2, 4'd2},
        {1'b1, 1'b1, 2'd0, 8'd5, 8'd5, 8'd1, 4'd4}
    };

    logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic [CNT_W-1:0]  start_count = '0;
    logic dir = 1'b0, burst = 1'b0, xfer_req = 1'b0;
    logic [1:0] unit_sel = 2'd0;
    logic bus_req, bus_gnt = 1'b0;
    logic [ADDR_W-1:0] mem_addr;
    logic mem_cs_n, mem_we_n, mem_rd_n, ack_n, done;

    int n_cmp = 0, n_bad = 0;
    int gdly = 0, gcnt = 0;
    bit mon = 1'b0, prev_req = 1'b0, prev_ack = 1'b0;
    int beats, acks, rels, ack_runs, addr_err, dir_err, gnt_err, req_seen;
    logic [ADDR_W-1:0] exp_addr, exp_step;

    always #2 clk = ~clk;

    sa_dma_channel #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_sa_dma_channel (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start_addr(start_addr),
        .start_count(start_count), .dir(dir), .burst(burst), .unit_sel(unit_sel),
        .xfer_req(xfer_req), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_rd_n(mem_rd_n), .ack_n(ack_n), .done(done)
    );

    // Arbiter model: grants after gdly cycles of request, drops with the request.
    always @(posedge clk) begin
        if (!bus_req) begin gcnt <= 0; bus_gnt <= 1'b0; end
        else if (gcnt >= gdly) bus_gnt <= 1'b1;
        else gcnt <= gcnt + 1;
    end

    // Monitor: accumulates access statistics on the falling edge.
    always @(negedge clk) begin
        if (mon) begin
            if (!mem_cs_n) begin
                beats++;
                if (mem_addr !== exp_addr) addr_err++;
                exp_addr = exp_addr + exp_step;
                if (mem_we_n !== dir || mem_rd_n !== !dir) dir_err++;
            end
            if (!ack_n) acks++;
            if (!ack_n && !prev_ack) ack_runs++;
            if (!bus_gnt && (!mem_cs_n || !ack_n)) gnt_err++;
            if (prev_req && !bus_req) rels++;
            if (bus_req) req_seen++;
            prev_req = bus_req;
            prev_ack = !ack_n;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clear_stats(input logic [ADDR_W-1:0] a, input logic [1:0] u);
        beats = 0; acks = 0; rels = 0; ack_runs = 0;
        addr_err = 0; dir_err = 0; gnt_err = 0; req_seen = 0;
        prev_req = 1'b0; prev_ack = 1'b0;
        exp_addr = a;
        exp_step = (u == 2'd3) ? ADDR_W'(4) : (ADDR_W'(1) << u);
    endtask

    task automatic setup(input logic d, input logic b, input logic [1:0] u,
                         input int cnt, input logic [ADDR_W-1:0] a);
        enable = 1'b0; xfer_req = 1'b0;
        dir = d; burst = b; unit_sel = u;
        start_count = CNT_W'(cnt); start_addr = a;
        tick(2);
        clear_stats(a, u);
        mon = 1'b1;
        enable = 1'b1;
    endtask

    task automatic run_vec(input int i);
        logic [31:0] v;
        logic [ADDR_W-1:0] a;
        int guard;
        v = VEC[i];
        a = ADDR_W'(32'h1000 + i * 256 + i);
        if (v[29:28] != 2'd0) a = a & ~ADDR_W'(3);
        gdly = int'(v[3:0]);
        setup(v[31], v[30], v[29:28], int'(v[27:20]), a);
        xfer_req = 1'b1;
        if (v[30]) begin tick(1); xfer_req = 1'b0; end
        guard = 0;
        while (done !== 1'b1 && guard < 400) begin @(negedge clk); guard++; end
        tick(4);
        xfer_req = 1'b0;
        @(negedge clk);
        mon = 1'b0;
        check(v[30] ? "R5 access count" : "R4 access count", beats, int'(v[19:12]));
        check(v[30] ? "R5 bus releases" : "R4 bus releases", rels, int'(v[11:4]));
        check("R6 address sequence errors", addr_err, 0);
        check("R6 ack runs", ack_runs, int'(v[11:4]));
        check("R1 strobe direction errors", dir_err, 0);
        check("R2 ack cycles equal accesses", acks, beats);
        check("R3 access without grant", gnt_err, 0);
        check("R7 done after run", int'(done), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R9: reset state
        tick(3);
        @(negedge clk);
        check("R9 bus_req", int'(bus_req), 0);
        check("R9 strobes idle", int'({mem_cs_n, mem_we_n, mem_rd_n, ack_n}), 15);
        check("R9 done", int'(done), 0);
        rst_n = 1'b1;
        tick(2);

        for (int i = 0; i < NVEC; i++) run_vec(i);

        // R7: zero count finishes with no access
        gdly = 0;
        setup(1'b0, 1'b0, 2'd0, 0, 26'h40);
        xfer_req = 1'b1;
        tick(10);
        @(negedge clk);
        check("R7 zero count done", int'(done), 1);
        check("R7 zero count accesses", beats, 0);
        check("R7 zero count no bus request", req_seen, 0);

        // R8: single requests, one remembered during the handshake
        gdly = 3;
        setup(1'b0, 1'b0, 2'd0, 3, 26'h200);
        xfer_req = 1'b1; tick(1); xfer_req = 1'b0;
        while (!(bus_req && !bus_gnt)) @(negedge clk);
        tick(1);
        xfer_req = 1'b1; tick(1); xfer_req = 1'b0;
        tick(30);
        @(negedge clk);
        check("R8 latched request served", beats, 2);
        check("R8 no unit without request", int'(done), 0);
        tick(1);
        xfer_req = 1'b1; tick(1); xfer_req = 1'b0;
        tick(30);
        @(negedge clk);
        check("R8 third request served", beats, 3);
        check("R7 done after last unit", int'(done), 1);
        check("R6 byte addresses", addr_err, 0);

        // R7: done held, requests ignored until enable falls
        tick(1);
        xfer_req = 1'b1; tick(1); xfer_req = 1'b0;
        tick(10);
        @(negedge clk);
        check("R7 no access after done", beats, 3);
        check("R7 done held", int'(done), 1);
        tick(1);
        enable = 1'b0;
        tick(1);
        @(negedge clk);
        check("R7 done cleared by enable low", int'(done), 0);

        // R10: requests ignored while disabled
        req_seen = 0;
        xfer_req = 1'b1;
        tick(10);
        xfer_req = 1'b0;
        @(negedge clk);
        check("R10 no bus request while disabled", req_seen, 0);
        check("R10 no access while disabled", beats, 3);
        mon = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule